// File: doc/BRIEF.md
# ATM Transmit Cell Source with Header Check and Payload Scrambling

This block feeds one transmit channel of a cell-based downstream link. Each time the frame builder asks for a cell, the block looks at the transmit cell FIFO. If a whole cell is waiting there, it reads that cell. If not, it supplies an idle cell in its place. Either way the link always receives a complete 53-octet cell. The block computes the header error control octet over the four header octets and emits it as octet 5. It passes the 48 payload octets through a self-synchronising scrambler whose state carries from one cell to the next.

The FIFO holds cells as 52 octets each: four header octets followed by 48 payload octets, with no HEC. It presents its head octet in show-ahead fashion and advances it when the block raises its read strobe. The block emits one octet on each clock while the transmit enable is high, and marks octet 1 of each cell with a start-of-cell strobe. A saturating counter records how many cells came from the FIFO. Idle cells do not add to it.

Top module: `atm_cell_tx`

## Requirements
- R1: While reset is asserted, and directly after it, out_valid, out_soc and fifo_rd are low and cell_cnt is zero.
- R2: A high cell_req is accepted only while no cell is in progress; requests made during a cell are ignored. The source is chosen in the accepting cycle. If fifo_cell_avail is high, the cell's header octets 1-4 and payload are taken from the FIFO in FIFO order. Otherwise an idle cell is produced.
- R3: Every accepted cell leaves as exactly 53 octets on out_data with out_valid high. out_soc is high on octet 1 only.
- R4: Octet 5 equals the CRC-8 of octets 1-4 XOR 0x55. The CRC uses generator x^8+x^2+x+1, starts from zero, and takes each octet MSB first.
- R5: An idle cell has header octets 00 00 00 01, so its octet 5 is 0x52. Its 48 payload octets are 0x6A before scrambling.
- R6: Payload octets are scrambled MSB first. Each output bit is the input bit XOR the output bit sent 43 payload bits earlier. The state is all zero after reset, carries across cells, and does not advance during octets 1-5.
- R7: In a cycle with tx_en low the block emits no octet, does not read the FIFO and does not advance its cell position or scrambler. out_valid is low in the following cycle.
- R8: fifo_rd is high exactly in the cycles in which the block consumes fifo_data, so that each FIFO octet is read once. That is 52 reads for each FIFO cell and none for idle cells.
- R9: cell_cnt increases by one for each accepted FIFO cell and not for idle cells. It stops at its all-ones value.
- R10: cnt_clr is synchronous. cell_cnt is zero in the cycle after cnt_clr is high, even when a FIFO cell is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_req | input | 1 | Frame builder asks for the next cell |
| tx_en | input | 1 | Emit one octet this cycle when high |
| fifo_cell_avail | input | 1 | FIFO holds at least one whole 52-octet cell |
| fifo_data | input | 8 | Show-ahead head octet of the FIFO |
| fifo_rd | output | 1 | Advance the FIFO head this cycle |
| out_data | output | 8 | Outgoing cell octet |
| out_valid | output | 1 | out_data carries an octet |
| out_soc | output | 1 | Current octet is octet 1 of a cell |
| cnt_clr | input | 1 | Synchronous clear of the cell counter |
| cell_cnt | output | CNT_W | Saturating count of cells taken from the FIFO |

## Verification
The checks on the outputs assume that fifo_cell_avail is raised only when a whole cell is buffered, and that fifo_data always shows the head octet after every read strobe, so a FIFO cell can never run dry part-way through. The bench models the FIFO as a queue. It raises availability only when 52 or more octets are queued, pops at the clock after a sampled read, and loads new cells only between runs. The bench drives cell_req, tx_en and cnt_clr away from the clock edge. It holds cell_req high until the last wanted start-of-cell appears, so acceptance happens only at the cell boundaries the block allows.

// File: rtl/atm_cell_tx_pkg.sv
package atm_cell_tx_pkg;
    localparam int HDR_OCTETS  = 4;
    localparam int PAY_OCTETS  = 48;
    localparam int CELL_OCTETS = HDR_OCTETS + 1 + PAY_OCTETS;
    localparam int IDX_W       = $clog2(CELL_OCTETS);
    localparam int SCR_LEN     = 43;

    localparam logic [IDX_W-1:0] IDX_HEC  = IDX_W'(HDR_OCTETS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_OCTETS - 1);

    localparam logic [7:0]              HEC_POLY  = 8'h07;
    localparam logic [7:0]              HEC_COSET = 8'h55;
    localparam logic [8*HDR_OCTETS-1:0] IDLE_HDR  = 32'h0000_0001;
    localparam logic [7:0]              IDLE_FILL = 8'h6A;

    typedef struct packed {
        logic               active;
        logic               idle;
        logic [IDX_W-1:0]   idx;
        logic [7:0]         crc;
        logic [SCR_LEN-1:0] scr;
        logic [7:0]         odata;
        logic               ovalid;
        logic               osoc;
    } seq_t;
endpackage

// File: rtl/atm_hec_step.sv
module atm_hec_step
    import atm_cell_tx_pkg::*;
(
    input  logic [7:0] crc_in,
    input  logic [7:0] octet,
    output logic [7:0] crc_out
);
    // one octet of the header CRC, most significant bit first
    always_comb begin
        logic [7:0] c;
        c = crc_in;
        for (int b = 7; b >= 0; b--) begin
            if (c[7] ^ octet[b]) begin
                c = {c[6:0], 1'b0} ^ HEC_POLY;
            end else begin
                c = {c[6:0], 1'b0};
            end
        end
        crc_out = c;
    end
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler #(
    parameter int LEN = 43
) (
    input  logic [LEN-1:0] state_in,
    input  logic [7:0]     octet_in,
    output logic [7:0]     octet_out,
    output logic [LEN-1:0] state_out
);
    // self-synchronising: each sent bit mixes with the bit sent LEN earlier
    always_comb begin
        logic [LEN-1:0] s;
        s         = state_in;
        octet_out = '0;
        for (int b = 7; b >= 0; b--) begin
            octet_out[b] = octet_in[b] ^ s[LEN-1];
            s            = {s[LEN-2:0], octet_out[b]};
        end
        state_out = s;
    end
endmodule

// File: rtl/atm_cell_counter.sv
module atm_cell_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/atm_cell_tx.sv
module atm_cell_tx
    import atm_cell_tx_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_req,
    input  logic             tx_en,
    input  logic             fifo_cell_avail,
    input  logic [7:0]       fifo_data,
    output logic             fifo_rd,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_soc,
    input  logic             cnt_clr,
    output logic [CNT_W-1:0] cell_cnt
);
    seq_t               seq_d, seq_q;
    logic [7:0]         src_octet;
    logic [7:0]         crc_nx;
    logic [7:0]         scr_octet;
    logic [SCR_LEN-1:0] scr_nx;
    logic               rd_c;
    logic               cnt_inc;

    // octet entering the cell: FIFO head, or the idle pattern
    always_comb begin
        src_octet = q_idle_fill();
        if (seq_q.idle) begin
            for (int k = 0; k < HDR_OCTETS; k++) begin
                if (seq_q.idx == IDX_W'(k)) begin
                    src_octet = IDLE_HDR[8*(HDR_OCTETS-1-k) +: 8];
                end
            end
        end
    end

    function automatic logic [7:0] q_idle_fill();
        return seq_q.idle ? IDLE_FILL : fifo_data;
    endfunction

    atm_hec_step u_hec (
        .crc_in  (seq_q.crc),
        .octet   (src_octet),
        .crc_out (crc_nx)
    );

    atm_payload_scrambler #(.LEN(SCR_LEN)) u_scr (
        .state_in  (seq_q.scr),
        .octet_in  (src_octet),
        .octet_out (scr_octet),
        .state_out (scr_nx)
    );

    always_comb begin
        seq_d        = seq_q;
        seq_d.ovalid = 1'b0;
        seq_d.osoc   = 1'b0;
        rd_c         = 1'b0;
        cnt_inc      = 1'b0;
        if (!seq_q.active) begin
            if (cell_req) begin
                seq_d.active = 1'b1;
                seq_d.idle   = !fifo_cell_avail;
                seq_d.idx    = '0;
                seq_d.crc    = '0;
                cnt_inc      = fifo_cell_avail;
            end
        end else if (tx_en) begin
            seq_d.ovalid = 1'b1;
            seq_d.osoc   = (seq_q.idx == '0);
            if (seq_q.idx < IDX_HEC) begin
                seq_d.odata = src_octet;
                seq_d.crc   = crc_nx;
                rd_c        = !seq_q.idle;
            end else if (seq_q.idx == IDX_HEC) begin
                seq_d.odata = seq_q.crc ^ HEC_COSET;
            end else begin
                seq_d.odata = scr_octet;
                seq_d.scr   = scr_nx;
                rd_c        = !seq_q.idle;
            end
            if (seq_q.idx == IDX_LAST) begin
                seq_d.active = 1'b0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    atm_cell_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cell_cnt)
    );

    assign fifo_rd   = rd_c;
    assign out_data  = seq_q.odata;
    assign out_valid = seq_q.ovalid;
    assign out_soc   = seq_q.osoc;
endmodule

// File: rtl/atm_cell_tx_chk.sv
module atm_cell_tx_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             cnt_clr,
    input logic             fifo_rd,
    input logic             out_valid,
    input logic             out_soc,
    input logic [CNT_W-1:0] cell_cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    p_soc_in_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    p_soc_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |=> !out_soc);

    p_stall_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !out_valid);

    p_stall_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !fifo_rd);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cell_cnt == '0));

    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ((cell_cnt == $past(cell_cnt)) || (cell_cnt == $past(cell_cnt) + 1'b1)));

    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cell_cnt == CNT_TOP) && !cnt_clr) |=> (cell_cnt == CNT_TOP));
endmodule

bind atm_cell_tx atm_cell_tx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .cnt_clr   (cnt_clr),
    .fifo_rd   (fifo_rd),
    .out_valid (out_valid),
    .out_soc   (out_soc),
    .cell_cnt  (cell_cnt)
);

// File: tb/tb_atm_cell_tx.sv
module tb_atm_cell_tx;
    import atm_cell_tx_pkg::*;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cell_req = 1'b0;
    logic          tx_en = 1'b0;
    logic          fifo_cell_avail = 1'b0;
    logic [7:0]    fifo_data = 8'h00;
    logic          cnt_clr = 1'b0;
    logic          fifo_rd;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          out_soc;
    logic [CW-1:0] cell_cnt;

    always #2 clk = ~clk;

    atm_cell_tx #(.CNT_W(CW)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cell_req        (cell_req),
        .tx_en           (tx_en),
        .fifo_cell_avail (fifo_cell_avail),
        .fifo_data       (fifo_data),
        .fifo_rd         (fifo_rd),
        .out_data        (out_data),
        .out_valid       (out_valid),
        .out_soc         (out_soc),
        .cnt_clr         (cnt_clr),
        .cell_cnt        (cell_cnt)
    );

    typedef struct {
        logic [7:0] d;
        bit         soc;
        bit         idle;
        int         pos;
    } exp_t;

    int           checks = 0;
    int           fails = 0;
    logic [7:0]   fifoq[$];
    exp_t         expq[$];
    exp_t         cur;
    logic [42:0]  m_scr = '0;
    int           pops = 0;
    int           socs = 0;
    int           target = 0;
    int           en_mode = 0;
    int           cyc = 0;
    bit           req_on = 1'b0;
    bit           clr_once = 1'b0;
    bit           rd_seen = 1'b0;
    bit           en_seen = 1'b1;
    int           seed = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [7:0] hec_model(input logic [7:0] h [4]);
        logic [7:0] c;
        c = 8'h00;
        for (int k = 0; k < 4; k++) begin
            for (int b = 7; b >= 0; b--) begin
                if (c[7] ^ h[k][b]) c = {c[6:0], 1'b0} ^ 8'h07;
                else                c = {c[6:0], 1'b0};
            end
        end
        return c ^ 8'h55;
    endfunction

    function automatic logic [7:0] scr_model(input logic [7:0] v);
        logic [7:0] o;
        for (int b = 7; b >= 0; b--) begin
            o[b]  = v[b] ^ m_scr[42];
            m_scr = {m_scr[41:0], o[b]};
        end
        return o;
    endfunction

    // monitor and FIFO model, all away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!en_seen) check(!out_valid, "R7 octet emitted after stalled cycle", 32'(out_valid), 0);
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2 octet beyond the requested cells", 32'(out_data), 0);
                end else begin
                    cur = expq.pop_front();
                    if (cur.idle)          check(out_data == cur.d, "R5 idle cell octet", 32'(out_data), 32'(cur.d));
                    else if (cur.pos < 4)  check(out_data == cur.d, "R2 FIFO header octet", 32'(out_data), 32'(cur.d));
                    else if (cur.pos == 4) check(out_data == cur.d, "R4 HEC octet", 32'(out_data), 32'(cur.d));
                    else                   check(out_data == cur.d, "R6 scrambled payload octet", 32'(out_data), 32'(cur.d));
                    check(out_soc == cur.soc, "R3 start-of-cell strobe", 32'(out_soc), 32'(cur.soc));
                end
                if (out_soc) socs++;
            end
        end
        if (rd_seen) begin
            if (fifoq.size() > 0) void'(fifoq.pop_front());
            pops++;
        end
        fifo_cell_avail = (fifoq.size() >= 52);
        fifo_data       = (fifoq.size() > 0) ? fifoq[0] : 8'h00;
        cyc++;
        case (en_mode)
            1:       tx_en = (cyc % 3) != 0;
            2:       tx_en = (cyc % 4) != 1;
            default: tx_en = 1'b1;
        endcase
        cell_req = req_on && (socs < target);
        cnt_clr  = clr_once;
        clr_once = 1'b0;
        #1;
        rd_seen = fifo_rd;
        en_seen = tx_en;
    end

    // driver: loads the FIFO, queues expected octets, requests the cells
    task automatic run_cells(input int n_fifo, input int n_total, input int mode, input bit clr);
        logic [7:0] h [4];
        logic [7:0] p;
        exp_t       e;
        bit         done;
        @(posedge clk);
        for (int c = 0; c < n_total; c++) begin
            seed++;
            for (int k = 0; k < 4; k++) begin
                if (c < n_fifo) h[k] = 8'(seed * 29 + k * 71 + 8'h13);
                else            h[k] = (k == 3) ? 8'h01 : 8'h00;
                if (c < n_fifo) fifoq.push_back(h[k]);
                e.d = h[k]; e.soc = (k == 0); e.idle = (c >= n_fifo); e.pos = k;
                expq.push_back(e);
            end
            e.d = hec_model(h); e.soc = 1'b0; e.pos = 4;
            expq.push_back(e);
            for (int i = 0; i < 48; i++) begin
                p = (c < n_fifo) ? 8'(seed * 7 + i * 13 + 8'h5C) : 8'h6A;
                if (c < n_fifo) fifoq.push_back(p);
                e.d = scr_model(p); e.pos = 5 + i;
                expq.push_back(e);
            end
        end
        pops     = 0;
        socs     = 0;
        target   = n_total;
        en_mode  = mode;
        clr_once = clr;
        req_on   = 1'b1;
        done     = 1'b0;
        for (int t = 0; t < 200 * n_total + 100; t++) begin
            @(posedge clk);
            if (socs >= target && expq.size() == 0) begin
                done = 1'b1;
                break;
            end
        end
        check(done, "R3 requested cells all delivered", 32'(expq.size()), 0);
        req_on = 1'b0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(socs == target, "R2 extra cell after requests ended", 32'(socs), 32'(target));
        check(pops == 52 * n_fifo, "R8 FIFO reads per run", 32'(pops), 32'(52 * n_fifo));
        check(fifoq.size() == 0, "R8 FIFO left with octets", 32'(fifoq.size()), 0);
        expq.delete();
        fifoq.delete();
    endtask

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog expired", 0, 0);
        finish_report();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check(!out_valid, "R1 out_valid in reset", 32'(out_valid), 0);
        check(!out_soc, "R1 out_soc in reset", 32'(out_soc), 0);
        check(!fifo_rd, "R1 fifo_rd in reset", 32'(fifo_rd), 0);
        check(cell_cnt == 0, "R1 cell_cnt in reset", 32'(cell_cnt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && !fifo_rd, "R1 quiet after reset", 32'({out_valid, fifo_rd}), 0);

        // two FIFO cells then two idle cells, continuous enable
        run_cells(2, 4, 0, 1'b0);
        check(cell_cnt == 2, "R9 count after FIFO and idle cells", 32'(cell_cnt), 2);

        // FIFO cells under periodic stalls
        run_cells(3, 3, 1, 1'b0);
        check(cell_cnt == 5, "R9 count after stalled run", 32'(cell_cnt), 5);

        // idle cells only, stalled: counter must not move
        run_cells(0, 2, 2, 1'b0);
        check(cell_cnt == 5, "R9 idle cells not counted", 32'(cell_cnt), 5);

        // plain clear
        @(posedge clk);
        clr_once = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(cell_cnt == 0, "R10 clear", 32'(cell_cnt), 0);

        // clear in the same cycle as a FIFO cell is accepted
        run_cells(1, 1, 0, 1'b1);
        check(cell_cnt == 0, "R10 clear beats increment", 32'(cell_cnt), 0);
        run_cells(1, 1, 0, 1'b0);
        check(cell_cnt == 1, "R9 count after clear", 32'(cell_cnt), 1);

        // saturation of the narrow counter
        run_cells(16, 16, 0, 1'b0);
        check(cell_cnt == {CW{1'b1}}, "R9 counter saturates", 32'(cell_cnt), 32'({CW{1'b1}}));

        finish_report();
    end
endmodule